// File: doc/BRIEF.md
# LPDDR4 Two-Rank Mode-Register Bring-Up Sequencer

This block is a hardware state machine that programs the mode registers of a two-rank LPDDR4 device after power-on, so that no software has to do it. A single start pulse begins the run. The block first waits for the power-on delay. It then takes rank 0 and rank 1 in turn. For each rank it forces CKE high, waits for the device to settle, and issues a fixed list of mode-register writes. It then releases the CKE force for that rank.

Every write goes out on a simple request interface to the memory controller: a rank, a register address, an 8-bit operand and an enable. The enable stays high until the controller reports completion. Both frequency set points are programmed through MR13. The working set point is written first while the device runs on the other one. The non-working set point is then written with the two DBI enables inverted. Last, both set-point selects are pointed at the working set. Refresh is enabled, and a done flag is raised, only after both ranks are finished.

All delays come from one shared down-counter. Each load value is the delay in nanoseconds divided by the clock-period parameter, rounded up.

Top module: `mr_init_seq`

## Requirements
- R1: After a start, CKE force for rank 0 rises no earlier than the power-on delay. The first write for a rank comes no earlier than the CKE settle delay after that rank's force rises. Every write goes out while only its own rank's force bit is high. Each force bit clears after the last write of its rank, and at most one force bit is ever high.
- R2: `refresh_en` and `done` stay 0 from the start until both ranks are finished. They then rise together, with both CKE force bits at 0.
- R3: A write presents rank, address and operand together with `mrw_en`. All of these hold steady while `mrw_resp` is 0. `mrw_en` drops on the clock edge that samples `mrw_resp` = 1.
- R4: Per rank the write order is fixed. It is: MR13, MR1, MR2, MR3, MR11, MR12, MR14, MR51 (only if enabled), MR13, MR1, MR2, MR3, MR11, MR12, MR14, MR13. The MR13 operand is 0x10 plus 0x80 times the operating-set bit plus 0x40 times the write-set bit. The three MR13 writes use (write, operate) = (W, not W), then (not W, W), then (W, W), where W is the working set.
- R5: The MR1 operand is read postamble in bit 7, the constant 5 in bits 6:4, read preamble in bit 3, write preamble in bit 2, and the burst-length code in bits 1:0.
- R6: The MR2 operand is the write-latency code in bits 5:3 and the read-latency code in bits 2:0. Bits 7:6 are 0.
- R7: The MR3 operand is write DBI in bit 7, read DBI in bit 6, the constant 5 in bits 5:3, and write postamble in bit 1. Bits 2 and 0 are 0. The second MR3 write of a rank carries both DBI bits inverted.
- R8: MR12 is 0x5D. MR11/MR14 are 0x00/0x5D when the working set is 0, and 0x04/0x18 when it is 1.
- R9: MR51 is written only when the LP4Y enable is 1, with operand 0x0E.
- R10: `mrw_en` stays low for at least the gap delay in three places: after the first MR13, after the first group of writes, and after the second MR13. Between other writes of a rank it is low for one cycle.
- R11: Each delay lasts ceil(delay_ns / CLK_NS) cycles. With CLK_NS = 5 that is 40 cycles for power-on, 80 for CKE settle and 3 for the gap.
- R12: A start while the sequence is running has no effect. After completion, `done`, `refresh_en` and CKE force keep their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| cfg_work_set | input | 1 | Working frequency set point |
| cfg_rd_post | input | 1 | Read postamble select |
| cfg_rd_pre | input | 1 | Read preamble select |
| cfg_wr_pre | input | 1 | Write preamble select |
| cfg_bl | input | 2 | Burst-length code |
| cfg_wl | input | 3 | Write-latency code |
| cfg_rl | input | 3 | Read-latency code |
| cfg_dbi_wr | input | 1 | Write DBI enable for the working set |
| cfg_dbi_rd | input | 1 | Read DBI enable for the working set |
| cfg_wr_post | input | 1 | Write postamble select |
| cfg_lp4y | input | 1 | Single-ended (LP4Y) mode enable |
| mrw_rank | output | 1 | Target rank of the write |
| mrw_addr | output | 6 | Mode-register address |
| mrw_op | output | 8 | Mode-register operand |
| mrw_en | output | 1 | Write request, held until completion |
| mrw_resp | input | 1 | Write completion from the controller |
| cke_force | output | 2 | Per-rank CKE force-on |
| refresh_en | output | 1 | Refresh enable |
| done | output | 1 | Sequence complete |

## Verification
The bench builds the block with CLK_NS = 5, to match its 200 MHz clock. This makes the power-on, CKE and gap delays 40, 80 and 3 cycles, so the rounding and the gap checks work on small exact numbers. The run stays short enough to cover three full sequences. These cover both working set points, the LP4Y enable on and off, and a start pulse in the middle of a run. Together they reach both MR11/MR14 pairs, the skipped MR51 slot and the DBI inversion in both directions. The controller's completion latency varies from write to write, which exercises the hold of the request fields.

// File: rtl/mr_init_pkg.sv
package mr_init_pkg;

  typedef struct packed {
    logic       work_set;
    logic       rd_post;
    logic       rd_pre;
    logic       wr_pre;
    logic [1:0] bl;
    logic [2:0] wl;
    logic [2:0] rl;
    logic       dbi_wr;
    logic       dbi_rd;
    logic       wr_post;
    logic       lp4y;
  } mr_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PWR, ST_CKE, ST_ISSUE, ST_RESP, ST_GAP
  } seq_state_t;

  localparam int          STEP_W     = 4;
  localparam int          ADDR_W     = 6;
  localparam logic [2:0]  NWR_CODE   = 3'd5;
  localparam logic [2:0]  DRIVE_CODE = 3'd5;
  localparam logic [7:0]  MR12_VAL   = 8'h5D;

  function automatic int delay_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [7:0] mr13_op(input logic wr_set, input logic op_set);
    return {op_set, wr_set, 1'b0, 1'b1, 4'b0000};
  endfunction

  function automatic logic [7:0] mr1_op(input mr_cfg_t c);
    return {c.rd_post, NWR_CODE, c.rd_pre, c.wr_pre, c.bl};
  endfunction

  function automatic logic [7:0] mr2_op(input mr_cfg_t c);
    return {2'b00, c.wl, c.rl};
  endfunction

  function automatic logic [7:0] mr3_op(input mr_cfg_t c, input logic invert_dbi);
    return {c.dbi_wr ^ invert_dbi, c.dbi_rd ^ invert_dbi, DRIVE_CODE,
            1'b0, c.wr_post, 1'b0};
  endfunction

  function automatic logic [7:0] mr11_op(input logic set);
    return set ? 8'h04 : 8'h00;
  endfunction

  function automatic logic [7:0] mr14_op(input logic set);
    return set ? 8'h18 : 8'h5D;
  endfunction

  function automatic logic [7:0] mr51_op(input logic lp4y);
    return {4'b0000, lp4y, lp4y, lp4y, 1'b0};
  endfunction

endpackage

// File: rtl/mr_step_table.sv
module mr_step_table
  import mr_init_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  mr_cfg_t          cfg,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]       op,
  output logic             skip,
  output logic             gap_after,
  output logic             last
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(15);

  always_comb begin
    addr      = '0;
    op        = '0;
    skip      = 1'b0;
    gap_after = 1'b0;
    unique case (step)
      4'd0:  begin addr = 6'd13; op = mr13_op(cfg.work_set, ~cfg.work_set); gap_after = 1'b1; end
      4'd1:  begin addr = 6'd1;  op = mr1_op(cfg); end
      4'd2:  begin addr = 6'd2;  op = mr2_op(cfg); end
      4'd3:  begin addr = 6'd3;  op = mr3_op(cfg, 1'b0); end
      4'd4:  begin addr = 6'd11; op = mr11_op(cfg.work_set); end
      4'd5:  begin addr = 6'd12; op = MR12_VAL; end
      4'd6:  begin addr = 6'd14; op = mr14_op(cfg.work_set); end
      4'd7:  begin addr = 6'd51; op = mr51_op(cfg.lp4y); skip = ~cfg.lp4y; gap_after = 1'b1; end
      4'd8:  begin addr = 6'd13; op = mr13_op(~cfg.work_set, cfg.work_set); gap_after = 1'b1; end
      4'd9:  begin addr = 6'd1;  op = mr1_op(cfg); end
      4'd10: begin addr = 6'd2;  op = mr2_op(cfg); end
      4'd11: begin addr = 6'd3;  op = mr3_op(cfg, 1'b1); end
      4'd12: begin addr = 6'd11; op = mr11_op(cfg.work_set); end
      4'd13: begin addr = 6'd12; op = MR12_VAL; end
      4'd14: begin addr = 6'd14; op = mr14_op(cfg.work_set); end
      default: begin addr = 6'd13; op = mr13_op(cfg.work_set, cfg.work_set); end
    endcase
  end

  assign last = (step == LAST_STEP);

endmodule

// File: rtl/mr_delay_timer.sv
module mr_delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == CNT_W'(1));

  AST_TIMER_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0)); // R11
  AST_TIMER_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R11

endmodule

// File: rtl/mr_write_port.sv
module mr_write_port
  import mr_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              rank_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        op_in,
  input  logic              mrw_resp,
  output logic              mrw_rank,
  output logic [ADDR_W-1:0] mrw_addr,
  output logic [7:0]        mrw_op,
  output logic              mrw_en,
  output logic              complete
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrw_rank <= 1'b0;
      mrw_addr <= '0;
      mrw_op   <= '0;
      mrw_en   <= 1'b0;
    end else if (issue) begin
      mrw_rank <= rank_in;
      mrw_addr <= addr_in;
      mrw_op   <= op_in;
      mrw_en   <= 1'b1;
    end else if (mrw_en && mrw_resp) begin
      mrw_en   <= 1'b0;
    end
  end

  assign complete = mrw_en && mrw_resp;

  AST_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mrw_en && !mrw_resp) |=> mrw_en); // R3
  AST_EN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mrw_en && mrw_resp) |=> !mrw_en); // R3
  AST_FIELDS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mrw_en && !mrw_resp) |=> ($stable(mrw_addr) && $stable(mrw_op) && $stable(mrw_rank))); // R3

endmodule

// File: rtl/mr_init_seq.sv
module mr_init_seq
  import mr_init_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int PWR_NS = 200,
  parameter int CKE_NS = 400,
  parameter int GAP_NS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cfg_work_set,
  input  logic       cfg_rd_post,
  input  logic       cfg_rd_pre,
  input  logic       cfg_wr_pre,
  input  logic [1:0] cfg_bl,
  input  logic [2:0] cfg_wl,
  input  logic [2:0] cfg_rl,
  input  logic       cfg_dbi_wr,
  input  logic       cfg_dbi_rd,
  input  logic       cfg_wr_post,
  input  logic       cfg_lp4y,
  output logic       mrw_rank,
  output logic [5:0] mrw_addr,
  output logic [7:0] mrw_op,
  output logic       mrw_en,
  input  logic       mrw_resp,
  output logic [1:0] cke_force,
  output logic       refresh_en,
  output logic       done
);
  localparam int PWR_CYC = delay_cycles(PWR_NS, CLK_NS);
  localparam int CKE_CYC = delay_cycles(CKE_NS, CLK_NS);
  localparam int GAP_CYC = delay_cycles(GAP_NS, CLK_NS);
  localparam int MAX_CYC = (PWR_CYC > CKE_CYC) ? ((PWR_CYC > GAP_CYC) ? PWR_CYC : GAP_CYC)
                                               : ((CKE_CYC > GAP_CYC) ? CKE_CYC : GAP_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  mr_cfg_t cfg;
  assign cfg = '{work_set: cfg_work_set, rd_post: cfg_rd_post, rd_pre: cfg_rd_pre,
                 wr_pre: cfg_wr_pre, bl: cfg_bl, wl: cfg_wl, rl: cfg_rl,
                 dbi_wr: cfg_dbi_wr, dbi_rd: cfg_dbi_rd, wr_post: cfg_wr_post,
                 lp4y: cfg_lp4y};

  seq_state_t        state, state_nx;
  logic [STEP_W-1:0] step;
  logic              rank;

  // named internal events
  logic              timer_load, timer_expire, issue_wr, wr_complete;
  logic              step_advance, rank_finished, seq_finished, start_taken;
  logic [CNT_W-1:0]  timer_val;
  logic [ADDR_W-1:0] tbl_addr;
  logic [7:0]        tbl_op;
  logic              tbl_skip, tbl_gap, tbl_last;

  mr_step_table u_table (
    .step(step), .cfg(cfg), .addr(tbl_addr), .op(tbl_op),
    .skip(tbl_skip), .gap_after(tbl_gap), .last(tbl_last)
  );

  mr_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val),
    .expire(timer_expire)
  );

  mr_write_port u_port (
    .clk(clk), .rst_n(rst_n), .issue(issue_wr), .rank_in(rank),
    .addr_in(tbl_addr), .op_in(tbl_op), .mrw_resp(mrw_resp),
    .mrw_rank(mrw_rank), .mrw_addr(mrw_addr), .mrw_op(mrw_op),
    .mrw_en(mrw_en), .complete(wr_complete)
  );

  always_comb begin
    logic step_over;
    state_nx     = state;
    timer_load   = 1'b0;
    timer_val    = '0;
    issue_wr     = 1'b0;
    step_advance = 1'b0;
    step_over    = 1'b0;
    start_taken  = 1'b0;
    unique case (state)
      ST_IDLE:  if (start) begin
                  start_taken = 1'b1;
                  state_nx    = ST_PWR;
                  timer_load  = 1'b1;
                  timer_val   = CNT_W'(PWR_CYC);
                end
      ST_PWR:   if (timer_expire) begin
                  state_nx   = ST_CKE;
                  timer_load = 1'b1;
                  timer_val  = CNT_W'(CKE_CYC);
                end
      ST_CKE:   if (timer_expire) state_nx = ST_ISSUE;
      ST_ISSUE: if (tbl_skip) step_over = 1'b1;
                else begin
                  issue_wr = 1'b1;
                  state_nx = ST_RESP;
                end
      ST_RESP:  if (wr_complete) step_over = 1'b1;
      ST_GAP:   if (timer_expire) step_advance = 1'b1;
      default:  state_nx = ST_IDLE;
    endcase

    if (step_over) begin
      if (tbl_gap) begin
        state_nx   = ST_GAP;
        timer_load = 1'b1;
        timer_val  = CNT_W'(GAP_CYC);
      end else begin
        step_advance = 1'b1;
      end
    end

    if (step_advance) begin
      if (!tbl_last)      state_nx = ST_ISSUE;
      else if (rank)      state_nx = ST_IDLE;
      else begin
        state_nx   = ST_CKE;
        timer_load = 1'b1;
        timer_val  = CNT_W'(CKE_CYC);
      end
    end
  end

  assign rank_finished = step_advance && tbl_last;
  assign seq_finished  = rank_finished && rank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      step       <= '0;
      rank       <= 1'b0;
      cke_force  <= 2'b00;
      refresh_en <= 1'b0;
      done       <= 1'b0;
    end else begin
      state <= state_nx;
      if (start_taken) begin
        done       <= 1'b0;
        refresh_en <= 1'b0;
        rank       <= 1'b0;
        step       <= '0;
      end
      if (state == ST_PWR && timer_expire) cke_force <= 2'b01;
      if (step_advance) step <= tbl_last ? '0 : step + 1'b1;
      if (rank_finished) begin
        if (rank) begin
          cke_force  <= 2'b00;
          refresh_en <= 1'b1;
          done       <= 1'b1;
        end else begin
          rank      <= 1'b1;
          cke_force <= 2'b10;
        end
      end
    end
  end

  AST_CKE_ONE_RANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cke_force)); // R1
  AST_WRITE_UNDER_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    mrw_en |-> (cke_force[mrw_rank] && $countones(cke_force) == 1)); // R1
  AST_REFRESH_AFTER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_en |-> (done && cke_force == 2'b00 && !mrw_en)); // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != ST_IDLE && state != ST_PWR) |=> (state != ST_PWR)); // R12
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && refresh_en)); // R12

endmodule

// File: tb/mr_init_seq_test.sv
`timescale 1ns/1ps
module mr_init_seq_test;

  typedef struct {
    logic       rank;
    logic [5:0] addr;
    logic [7:0] op;
    logic       gap_before;
  } exp_wr_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic c_set = 0, c_rpost = 0, c_rpre = 0, c_wpre = 0, c_dbiw = 0, c_dbir = 0, c_wpost = 0, c_lp4y = 0;
  logic [1:0] c_bl = 0;
  logic [2:0] c_wl = 0, c_rl = 0;
  logic       mrw_rank, mrw_en, refresh_en, done;
  logic       mrw_resp = 1'b0;
  logic [5:0] mrw_addr;
  logic [7:0] mrw_op;
  logic [1:0] cke_force;

  int compared = 0, mismatched = 0;
  exp_wr_t sb[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  mr_init_seq #(.CLK_NS(5)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_work_set(c_set), .cfg_rd_post(c_rpost), .cfg_rd_pre(c_rpre), .cfg_wr_pre(c_wpre),
    .cfg_bl(c_bl), .cfg_wl(c_wl), .cfg_rl(c_rl), .cfg_dbi_wr(c_dbiw), .cfg_dbi_rd(c_dbir),
    .cfg_wr_post(c_wpost), .cfg_lp4y(c_lp4y),
    .mrw_rank(mrw_rank), .mrw_addr(mrw_addr), .mrw_op(mrw_op), .mrw_en(mrw_en),
    .mrw_resp(mrw_resp), .cke_force(cke_force), .refresh_en(refresh_en), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected operands, computed arithmetically from the requirements
  function automatic int e_mr13(input int wr, input int opset);
    return 16 + 128 * opset + 64 * wr;
  endfunction

  task automatic push(input int r, input int a, input int v, input bit g);
    exp_wr_t e;
    e.rank = r[0]; e.addr = a[5:0]; e.op = v[7:0]; e.gap_before = g;
    sb.push_back(e);
  endtask

  task automatic push_rank(input int r);
    int w, mr1, mr2, mr3a, mr3b, mr11, mr14;
    w    = c_set;
    mr1  = 128 * c_rpost + 80 + 8 * c_rpre + 4 * c_wpre + c_bl;        // R5
    mr2  = 8 * c_wl + c_rl;                                             // R6
    mr3a = 128 * c_dbiw + 64 * c_dbir + 40 + 2 * c_wpost;               // R7
    mr3b = 128 * (1 - c_dbiw) + 64 * (1 - c_dbir) + 40 + 2 * c_wpost;   // R7
    mr11 = (w == 1) ? 4 : 0;                                            // R8
    mr14 = (w == 1) ? 24 : 93;                                          // R8
    push(r, 13, e_mr13(w, 1 - w), 1);                                   // R4
    push(r, 1, mr1, 1);                                                 // R10
    push(r, 2, mr2, 0);
    push(r, 3, mr3a, 0);
    push(r, 11, mr11, 0);
    push(r, 12, 93, 0);
    push(r, 14, mr14, 0);
    if (c_lp4y) push(r, 51, 14, 0);                                     // R9
    push(r, 13, e_mr13(1 - w, w), 1);
    push(r, 1, mr1, 1);
    push(r, 2, mr2, 0);
    push(r, 3, mr3b, 0);
    push(r, 11, mr11, 0);
    push(r, 12, 93, 0);
    push(r, 14, mr14, 0);
    push(r, 13, e_mr13(w, w), 0);
  endtask

  // controller model: variable completion latency
  int lat_seed = 0;
  initial begin
    int waited = 0;
    forever begin
      @(negedge clk);
      if (!mrw_en) begin
        mrw_resp = 1'b0;
        waited = 0;
      end else begin
        if (waited >= (lat_seed % 3)) mrw_resp = 1'b1;
        waited++;
        if (mrw_resp) lat_seed++;
      end
    end
  end

  // monitor: pops expected writes as the design issues them
  initial begin
    bit prev_en = 0;
    int low_cnt = 100;
    forever begin
      @(negedge clk);
      if (mrw_en && !prev_en) begin
        if (sb.size() == 0) begin
          chk(0, "R12 unexpected write", mrw_addr, 0);
        end else begin
          exp_wr_t e;
          e = sb.pop_front();
          chk(mrw_addr == e.addr, "R4 address order", mrw_addr, e.addr);
          chk(mrw_op == e.op, "R5-8 operand", mrw_op, e.op);
          chk(mrw_rank == e.rank, "R1 rank", mrw_rank, e.rank);
          chk(cke_force == (2'b01 << e.rank), "R1 cke during write", cke_force, 2'b01 << e.rank);
          chk(!refresh_en && !done, "R2 refresh held off", {refresh_en, done}, 0);
          if (e.gap_before) chk(low_cnt >= 3, "R10 gap", low_cnt, 3);
          else              chk(low_cnt <= 2, "R10 no gap", low_cnt, 1);
        end
      end
      if (mrw_en) low_cnt = 0; else low_cnt++;
      prev_en = mrw_en;
    end
  end

  task automatic run_seq(input bit poke_busy);
    int n;
    push_rank(0);
    push_rank(1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 1;
    while (!cke_force[0] && n < 1000) begin @(negedge clk); n++; end
    chk(n >= 40 && n <= 42, "R11 power-on delay", n, 41);
    chk(!refresh_en && !done, "R2 cleared at start", {refresh_en, done}, 0);
    n = 0;
    while (!mrw_en && n < 1000) begin @(negedge clk); n++; end
    chk(n >= 80 && n <= 82, "R1 cke settle", n, 81);
    if (poke_busy) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!cke_force[1] && n < 5000) begin @(negedge clk); n++; end
    chk(cke_force == 2'b10, "R1 rank 1 forced alone", cke_force, 2);
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done && refresh_en, "R2 done with refresh", {done, refresh_en}, 3);
    chk(cke_force == 2'b00, "R1 cke released", cke_force, 0);
    chk(sb.size() == 0, "R4 all writes seen", sb.size(), 0);
    repeat (20) @(negedge clk);
    chk(done && refresh_en && cke_force == 0 && !mrw_en, "R12 outputs hold",
        {done, refresh_en, cke_force, mrw_en}, 12);
    sb.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mrw_en == 0 && cke_force == 0 && !refresh_en && !done, "R2 reset state",
        {mrw_en, cke_force, refresh_en, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // set 0, LP4Y on
    c_set = 0; c_rpost = 1; c_rpre = 0; c_wpre = 1; c_bl = 2'd1; c_wl = 3'd3; c_rl = 3'd5;
    c_dbiw = 1; c_dbir = 0; c_wpost = 1; c_lp4y = 1;
    run_seq(0);
    // set 1, LP4Y off, busy start pulse
    c_set = 1; c_rpost = 0; c_rpre = 1; c_wpre = 0; c_bl = 2'd2; c_wl = 3'd6; c_rl = 3'd2;
    c_dbiw = 0; c_dbir = 1; c_wpost = 0; c_lp4y = 0;
    run_seq(1);
    // set 0, LP4Y off, all-ones fields
    c_set = 0; c_rpost = 1; c_rpre = 1; c_wpre = 1; c_bl = 2'd3; c_wl = 3'd7; c_rl = 3'd7;
    c_dbiw = 1; c_dbir = 1; c_wpost = 1; c_lp4y = 0;
    run_seq(0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule